// File: doc/BRIEF.md
# Serial PCM Stereo Input Receiver

This block takes a stereo audio stream delivered on three wires (a bit clock, a word clock and a serial data line) and turns it into parallel signed samples in the system-clock domain. The system clock runs at 384 times the sample rate, so every external wire is treated as a slow asynchronous level. Each wire passes through a two-flop synchroniser, and edges are found by comparing each synchronised level with its value one cycle earlier.

A bit is taken on every falling edge of the bit clock. Each change of the word clock closes a half-frame. The most recent 16 bits are then issued as one two's complement sample, with a channel flag and a single-cycle valid strobe. Only the newest 16 bits count, so a half-frame may carry any number of bit clocks from 16 upward. The leading surplus bits are discarded, and a word is always aligned to the word-clock edge.

Top module: `serial_pcm_rx`

## Requirements
- R1: The 16 bits of a sample are received most significant first, and `smp_o` gives them as a two's complement value in which the earliest of the 16 bits is bit 15.
- R2: A data bit is taken only at a falling edge of `bclk_i`. The level of `sdata_i` at a rising edge, or while the bit clock is low, has no effect on the sample.
- R3: When a half-frame holds more than 16 falling bit-clock edges, only the last 16 before the word-clock change form the sample, and the earlier bits are discarded.
- R4: A half-frame with `wclk_i` high carries the left channel and gives `smp_right_o` = 0. A half-frame with `wclk_i` low gives `smp_right_o` = 1.
- R5: Each word-clock transition that closes a complete word raises `smp_valid_o` for exactly one system-clock cycle. Exactly one strobe is issued per such transition.
- R6: A word-clock transition preceded by fewer than 16 falling bit-clock edges (counted since the previous transition or since reset) issues no strobe.
- R7: While `rst_n` is low at a clock edge, the block clears its shift register and its outputs: `smp_o` = 0, `smp_valid_o` = 0 and `smp_right_o` = 0.
- R8: When a falling bit-clock edge and a word-clock transition reach the system-clock domain in the same cycle, that bit is the least significant bit of the word being closed.
- R9: `smp_o` and `smp_right_o` change only in a cycle in which `smp_valid_o` is high, and they hold their value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 384 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| wclk_i | input | 1 | Word clock at the sample rate; high means left |
| sdata_i | input | 1 | Serial data, MSB first |
| smp_o | output | 16 | Received signed sample |
| smp_right_o | output | 1 | 1 for a right-channel sample, 0 for left |
| smp_valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
Two events can land in the same system-clock cycle: the capture of the final bit of a word, and the word-clock transition that closes that word. The bench provokes this by toggling the word clock in the same time step as the last falling bit-clock edge of some half-frames. In other half-frames it toggles the word clock only at the next rising edge. Both styles must give an identical sample, with the coincident bit as its LSB. A scoreboard queue holds the expected values and compares each strobe against them. Half-frames of 16, 20, 24 and 32 bits are mixed with too-short ones that must not strobe. Noise on the data line around the bit-clock rising edge checks that only falling edges sample.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    localparam int unsigned DEF_WORD_W      = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned LANES           = 3;   // bit clock, word clock, data
    localparam int unsigned LANE_BCLK       = 0;
    localparam int unsigned LANE_WCLK       = 1;
    localparam int unsigned LANE_DATA       = 2;
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic wclk_s,
    output logic bit_fall,
    output logic word_edge
);
    typedef struct packed {
        logic bclk_prev;
        logic wclk_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.bclk_prev = bclk_s;
        st_d.wclk_prev = wclk_s;
        bit_fall       = st_q.bclk_prev & ~bclk_s;
        word_edge      = st_q.wclk_prev ^ wclk_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A falling edge needs a high level one cycle earlier
    AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bit_fall |-> ($past(bclk_s) && !bclk_s)); // R2
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              data_s,
    input  logic              word_edge,
    output logic [WORD_W-1:0] word_nx,
    output logic              word_full
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        // a bit arriving with the word edge still belongs to the closing word
        word_nx = bit_fall ? {st_q.word[WORD_W-2:0], data_s} : st_q.word;
        cnt_nx  = (bit_fall && st_q.cnt != CNT_MAX) ? st_q.cnt + 1'b1 : st_q.cnt;
        word_full = (cnt_nx == CNT_MAX);
        st_d.word = word_nx;
        st_d.cnt  = word_edge ? '0 : cnt_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX); // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        word_edge |=> (st_q.cnt == '0)); // R6
endmodule

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] smp_o,
    output logic              smp_right_o,
    output logic              smp_valid_o
);
    logic [LANES-1:0] lanes_async, lanes_s;
    logic bit_fall, word_edge, word_full;
    logic [WORD_W-1:0] word_nx;

    typedef struct packed {
        logic [WORD_W-1:0] smp;
        logic              right;
        logic              valid;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        lanes_async = '0;
        lanes_async[LANE_BCLK] = bclk_i;
        lanes_async[LANE_WCLK] = wclk_i;
        lanes_async[LANE_DATA] = sdata_i;
    end

    pcm_rx_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(lanes_async), .sync_o(lanes_s)
    );

    pcm_rx_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .bclk_s(lanes_s[LANE_BCLK]), .wclk_s(lanes_s[LANE_WCLK]),
        .bit_fall(bit_fall), .word_edge(word_edge)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .bit_fall(bit_fall), .data_s(lanes_s[LANE_DATA]),
        .word_edge(word_edge), .word_nx(word_nx), .word_full(word_full)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (word_edge && word_full) begin
            st_d.smp   = word_nx;
            // word clock now high means the low (right) half just ended
            st_d.right = lanes_s[LANE_WCLK];
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o       = st_q.smp;
    assign smp_right_o = st_q.right;
    assign smp_valid_o = st_q.valid;

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(word_edge)); // R5
    AST_STROBE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(word_full)); // R6
    AST_CHANNEL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_right_o == $past(lanes_s[LANE_WCLK]))); // R4
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> ($stable(smp_o) && $stable(smp_right_o))); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (smp_o == '0 && !smp_valid_o)); // R7
endmodule

// File: tb/tb_serial_pcm_rx.sv
module tb_serial_pcm_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk_i = 1'b0, wclk_i = 1'b0, sdata_i = 1'b0;
    logic [15:0] smp_o;
    logic smp_right_o, smp_valid_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [16:0] expq[$];   // {right, sample}
    logic [15:0] lfsr = 16'hACE1;
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    serial_pcm_rx dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .wclk_i(wclk_i),
        .sdata_i(sdata_i), .smp_o(smp_o), .smp_right_o(smp_right_o),
        .smp_valid_o(smp_valid_o)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic noise();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One half-frame: word clock at 'level', nbits bit clocks, last 16 carry val.
    // coinc: toggle word clock together with the final falling edge (R8).
    task automatic send_half(input logic level, input logic [15:0] val,
                             input int nbits, input bit coinc);
        if (nbits >= 16) expq.push_back({~level, val});   // R4: high = left
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i >= nbits - 16) ? val[nbits - 1 - i] : noise();  // R1, R3
            bclk_i = 1'b1; wclk_i = level; sdata_i = noise();      // R2 noise at rise
            wait_cyc(2);
            sdata_i = b;
            wait_cyc(2);
            bclk_i = 1'b0;
            if (coinc && i == nbits - 1) wclk_i = ~level;
            wait_cyc(2);
            sdata_i = ~b;                                          // R2 noise while low
            wait_cyc(2);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (smp_valid_o && prev_valid)
                check(1'b0, "R5 strobe wider than one cycle", 32'd1, 32'd0);
            if (smp_valid_o) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", {15'd0, smp_right_o, smp_o}, 32'd0);
                end else begin
                    logic [16:0] e;
                    e = expq.pop_front();
                    check(smp_o == e[15:0], "R1 R3 R8 sample value", {16'd0, smp_o}, {16'd0, e[15:0]});
                    check(smp_right_o == e[16], "R4 channel flag", {31'd0, smp_right_o}, {31'd0, e[16]});
                end
            end
        end
        prev_valid = smp_valid_o;
    end

    initial begin
        wait_cyc(3);
        check(smp_o == 16'd0 && !smp_valid_o, "R7 reset state", {15'd0, smp_valid_o, smp_o}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        send_half(1'b1, 16'h0000, 10, 1'b0);   // R6 short first word
        send_half(1'b0, 16'h8001, 16, 1'b0);
        send_half(1'b1, 16'h7FFE, 16, 1'b0);
        send_half(1'b0, 16'hA5A5, 24, 1'b0);   // R3 long frames
        send_half(1'b1, 16'h5A5A, 24, 1'b0);
        send_half(1'b0, 16'h1234, 16, 1'b1);   // R8 coincident edges
        send_half(1'b1, 16'hFFFE, 16, 1'b1);
        send_half(1'b0, 16'h0000, 32, 1'b1);
        send_half(1'b1, 16'hFFFF, 20, 1'b0);
        send_half(1'b0, 16'h4321, 15, 1'b0);   // R6 short mid-stream
        send_half(1'b1, 16'hC3C3, 16, 1'b0);
        send_half(1'b0, 16'h0000, 4, 1'b0);    // trailing edge closes previous word
        bclk_i = 1'b1;
        wait_cyc(20);
        check(expq.size() == 0, "R5 one strobe per closed word", expq.size(), 32'd0);
        check(!smp_valid_o, "R9 idle after stream", {31'd0, smp_valid_o}, 32'd0);
        check(smp_o == 16'hC3C3, "R9 sample held", {16'd0, smp_o}, 32'hC3C3);
        rst_n = 1'b0;
        wait_cyc(2);
        check(smp_o == 16'd0 && !smp_valid_o && !smp_right_o, "R7 reset clears outputs",
              {15'd0, smp_valid_o, smp_o}, 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule